// File: doc/BRIEF.md
# Disk Drive Register and Command Unit

This block keeps the register set for a group of up to eight fixed-head disk drives that share one register-addressed peripheral bus. The bus presents a drive number, a register offset, a single-cycle access strobe with a read/write flag and 16-bit write data. Reads return data in the same cycle. An offset outside the eight defined registers gives a nonexistent-register flag and zero data.

Writing the control register with its start bit set issues a command. The block decodes the function field and checks the command against the drive's error state, whether a medium is present and whether the address is legal. It then either latches an error with attention, or sends a one-cycle start request to a separate timing unit. That unit later returns a completion pulse for the drive. Drive status is never stored. It is built from the live drive conditions and the stored error, attention and busy state, so it is always current.

Top module: `diskRegUnit`

## Requirements
- R1: Register offsets are 0 control, 1 status, 2 error, 3 maintenance, 4 attention summary, 5 address, 6 type and 7 look-ahead (`lookAhead` input).
  - Maintenance reads back what was written.
  - The type register reads 2 when `bigType` is set for the drive and 0 otherwise.
  - A control read always has bit 11 set.
  - Offsets 8 and above raise `nxReg` with zero read data.
- R2: Only control bits 5:1 (the function field) are stored, and they read back in place. Writes to the error, status, type and look-ahead registers change nothing.
- R3: A start (control write with bit 0 set) carrying a function field value other than 0, 2, 6, 10, 12 or 14 sets error bit 0 and raises attention on that drive.
- R4: A start first clears the drive's attention. If the drive already holds any error and the field is not 2 (drive clear), error bit 0 is set and attention is raised again.
- R5: Field 2 (drive clear) zeros the error register. Field 0 (no-op) changes nothing.
- R6: While a drive is busy, any write to it at an offset other than 4 is not performed. Instead it sets error bit 2 and raises attention. Attention-summary writes still take effect.
- R7: For a search (6), write-check (10), write (12) or read (14):
  - with no medium, error bit 14 is set;
  - otherwise, if address bits 14:12 are nonzero, error bit 10 is set.
  Either error raises attention and gives no start request.
- R8: A legal search or transfer pulses `startOp` for one cycle, one cycle after the start write, carrying the drive, the function field and the address. The drive becomes busy: status bit 7 (ready) clears, and bit 13 (positioning) sets for a search.
- R9: A `doneValid` pulse for a busy drive ends busy and restores ready. A completing search also raises attention.
- R10: Status of an enabled drive is built as follows:
  - bit 8 is always 1;
  - bit 12 follows the medium;
  - bit 11 is set when the lock is enabled, a medium is present and address bits 11:6 are at or below the drive's lock-track value;
  - bit 14 is set when any error bit is set;
  - bit 15 is the drive's attention.
- R11: The attention summary reads bit i as drive i's attention. Writing it clears attention on every drive whose data bit is 1. `attnOut` is the OR of all attention flags.
- R12: After reset, control, error, address and maintenance read 0 and ready is set. A drive with `driveEn` low reads status and error as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Register access strobe, one cycle per access |
| accWr | input | 1 | 1 = write, 0 = read |
| accDrv | input | 3 | Selected drive |
| accOfs | input | 5 | Register offset |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data (combinational) |
| nxReg | output | 1 | Nonexistent-register indication |
| attnOut | output | 1 | OR of all drive attention flags |
| driveEn | input | 8 | Drive enabled, one bit per drive |
| mediumOn | input | 8 | Medium present, one bit per drive |
| lockEn | input | 8 | Write lock enabled, one bit per drive |
| lockTrack | input | 48 | Six-bit lock-track value per drive, drive i at bits 6i+5:6i |
| bigType | input | 8 | Large drive type, one bit per drive |
| lookAhead | input | 16 | Rotational position from the timing unit |
| startOp | output | 1 | One-cycle start request to the timing unit |
| startDrive | output | 3 | Drive of the start request |
| startFunc | output | 5 | Function field of the start request |
| startAddr | output | 16 | Address register of the drive at start |
| doneValid | input | 1 | Completion pulse from the timing unit |
| doneDrive | input | 3 | Drive that completed |

## Verification
The assertions assume the following about the inputs:
- at most one access per cycle, and access inputs held steady between clock edges;
- `mediumOn` does not change in the cycle between a start write and its start request;
- `doneValid` names only a drive that the timing unit was actually told to start.

The directed stimulus keeps to these limits. It changes drive conditions only while the drives are idle, and sends each completion only after the matching start request has been seen.

// File: rtl/diskRegPkg.sv
package diskRegPkg;
  localparam int DRV_N  = 8;
  localparam int DRV_W  = $clog2(DRV_N);
  localparam int DATA_W = 16;
  localparam int OFS_W  = 5;
  localparam int FN_W   = 5;
  localparam int TRK_W  = 6;
  localparam int TRK_LSB = 6;

  typedef enum logic [2:0] {
    OFS_CTL, OFS_STAT, OFS_ERR, OFS_MAINT, OFS_ATTN, OFS_ADDR, OFS_TYPE, OFS_LOOK
  } regSelT;

  localparam logic [FN_W-1:0] FN_NOP   = 5'd0;
  localparam logic [FN_W-1:0] FN_CLR   = 5'd2;
  localparam logic [FN_W-1:0] FN_SEEK  = 5'd6;
  localparam logic [FN_W-1:0] FN_WCHK  = 5'd10;
  localparam logic [FN_W-1:0] FN_WRITE = 5'd12;
  localparam logic [FN_W-1:0] FN_READ  = 5'd14;

  localparam int ERB_ILLFN  = 0;
  localparam int ERB_REFUSE = 2;
  localparam int ERB_BADADR = 10;
  localparam int ERB_UNSAFE = 14;

  typedef struct packed {
    logic [DRV_W-1:0]  drv;
    logic              ldCtl;
    logic              ldAddr;
    logic              ldMaint;
    logic              clrErr;
    logic [DATA_W-1:0] setErr;
    logic              clrAttnSel;
    logic              setAttnSel;
    logic [DRV_N-1:0]  clrAttnMask;
    logic              launch;
  } ctrlStrobeT;
endpackage

// File: rtl/diskRegCtrl.sv
module diskRegCtrl
  import diskRegPkg::*;
(
  input  logic              accEn,
  input  logic              accWr,
  input  logic [DRV_W-1:0]  accDrv,
  input  logic [OFS_W-1:0]  accOfs,
  input  logic [DATA_W-1:0] wrData,
  input  logic              selBusy,
  input  logic              selErrAny,
  input  logic              selMedium,
  input  logic [2:0]        selAddrHi,
  output ctrlStrobeT        stb,
  output logic              nxReg
);
  logic            isReg;
  logic            isXfer;
  logic [FN_W-1:0] fn;
  regSelT          regSel;

  assign isReg  = (accOfs < OFS_W'(8));
  assign regSel = regSelT'(accOfs[2:0]);
  assign fn     = wrData[FN_W:1];
  assign isXfer = (fn == FN_SEEK) || (fn == FN_WCHK) || (fn == FN_WRITE) || (fn == FN_READ);
  assign nxReg  = accEn && !isReg;

  always_comb begin
    stb     = '0;
    stb.drv = accDrv;
    if (accEn && accWr) begin
      if (selBusy && !(isReg && regSel == OFS_ATTN)) begin
        stb.setErr[ERB_REFUSE] = 1'b1;
        stb.setAttnSel         = 1'b1;
      end else if (isReg) begin
        unique case (regSel)
          OFS_CTL: begin
            stb.ldCtl = 1'b1;
            if (wrData[0]) begin
              stb.clrAttnSel = 1'b1;
              if (selErrAny && fn != FN_CLR) begin
                stb.setErr[ERB_ILLFN] = 1'b1;
                stb.setAttnSel        = 1'b1;
              end else if (fn == FN_CLR) begin
                stb.clrErr = 1'b1;
              end else if (fn == FN_NOP) begin
                stb.clrErr = 1'b0;
              end else if (isXfer) begin
                if (!selMedium) begin
                  stb.setErr[ERB_UNSAFE] = 1'b1;
                  stb.setAttnSel         = 1'b1;
                end else if (selAddrHi != 3'b000) begin
                  stb.setErr[ERB_BADADR] = 1'b1;
                  stb.setAttnSel         = 1'b1;
                end else begin
                  stb.launch = 1'b1;
                end
              end else begin
                stb.setErr[ERB_ILLFN] = 1'b1;
                stb.setAttnSel        = 1'b1;
              end
            end
          end
          OFS_ADDR:  stb.ldAddr      = 1'b1;
          OFS_MAINT: stb.ldMaint     = 1'b1;
          OFS_ATTN:  stb.clrAttnMask = wrData[DRV_N-1:0];
          default:   stb.ldCtl       = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/diskRegPath.sv
module diskRegPath
  import diskRegPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             stb,
  input  logic [DRV_W-1:0]       accDrv,
  input  logic [OFS_W-1:0]       accOfs,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [DRV_N-1:0]       driveEn,
  input  logic [DRV_N-1:0]       mediumOn,
  input  logic [DRV_N-1:0]       lockEn,
  input  logic [DRV_N*TRK_W-1:0] lockTrack,
  input  logic [DRV_N-1:0]       bigType,
  input  logic [DATA_W-1:0]      lookAhead,
  input  logic                   doneValid,
  input  logic [DRV_W-1:0]       doneDrive,
  output logic [DATA_W-1:0]      rdData,
  output logic                   attnOut,
  output logic                   startOp,
  output logic [DRV_W-1:0]       startDrive,
  output logic [FN_W-1:0]        startFunc,
  output logic [DATA_W-1:0]      startAddr,
  output logic                   selBusy,
  output logic                   selErrAny,
  output logic [2:0]             selAddrHi
);
  logic [DRV_N-1:0][FN_W-1:0]   ctlQ;
  logic [DRV_N-1:0][DATA_W-1:0] errQ, addrQ, maintQ, statW, errNext;
  logic [DRV_N-1:0]             attnQ, busyQ, seekQ, attnNext, busyNext;

  always_comb begin
    for (int d = 0; d < DRV_N; d++) begin
      logic hit, fin;
      hit = (stb.drv == DRV_W'(d));
      fin = doneValid && (doneDrive == DRV_W'(d)) && busyQ[d];
      errNext[d]  = ((hit && stb.clrErr) ? '0 : errQ[d]) | (hit ? stb.setErr : '0);
      attnNext[d] = attnQ[d] && !stb.clrAttnMask[d] && !(hit && stb.clrAttnSel);
      if ((hit && stb.setAttnSel) || (fin && seekQ[d])) attnNext[d] = 1'b1;
      busyNext[d] = (busyQ[d] && !fin) || (hit && stb.launch);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0; errQ <= '0; addrQ <= '0; maintQ <= '0;
      attnQ <= '0; busyQ <= '0; seekQ <= '0;
      startOp <= 1'b0; startDrive <= '0; startFunc <= '0; startAddr <= '0;
    end else begin
      errQ    <= errNext;
      attnQ   <= attnNext;
      busyQ   <= busyNext;
      startOp <= stb.launch;
      if (stb.launch) begin
        startDrive       <= stb.drv;
        startFunc        <= wrData[FN_W:1];
        startAddr        <= addrQ[stb.drv];
        seekQ[stb.drv]   <= (wrData[FN_W:1] == FN_SEEK);
      end
      if (stb.ldCtl)   ctlQ[stb.drv]   <= wrData[FN_W:1];
      if (stb.ldAddr)  addrQ[stb.drv]  <= wrData;
      if (stb.ldMaint) maintQ[stb.drv] <= wrData;
    end
  end

  for (genvar g = 0; g < DRV_N; g++) begin : gStat
    logic wlk;
    assign wlk = lockEn[g] && mediumOn[g] &&
                 (addrQ[g][TRK_LSB +: TRK_W] <= lockTrack[g*TRK_W +: TRK_W]);
    assign statW[g] = driveEn[g] ?
      {attnQ[g], (errQ[g] != '0), busyQ[g] && seekQ[g], mediumOn[g], wlk,
       2'b00, 1'b1, !busyQ[g], 7'b0} : '0;
  end

  always_comb begin
    rdData = '0;
    if (accOfs < OFS_W'(8)) begin
      unique case (regSelT'(accOfs[2:0]))
        OFS_CTL:   rdData = DATA_W'(16'h0800) | DATA_W'({ctlQ[accDrv], 1'b0});
        OFS_STAT:  rdData = statW[accDrv];
        OFS_ERR:   rdData = driveEn[accDrv] ? errQ[accDrv] : '0;
        OFS_MAINT: rdData = maintQ[accDrv];
        OFS_ATTN:  rdData = DATA_W'(attnQ);
        OFS_ADDR:  rdData = addrQ[accDrv];
        OFS_TYPE:  rdData = {{(DATA_W-2){1'b0}}, bigType[accDrv], 1'b0};
        OFS_LOOK:  rdData = lookAhead;
        default:   rdData = '0;
      endcase
    end
  end

  assign attnOut   = |attnQ;
  assign selBusy   = busyQ[accDrv];
  assign selErrAny = (errQ[accDrv] != '0);
  assign selAddrHi = addrQ[accDrv][14:12];
endmodule

// File: rtl/diskRegUnit.sv
module diskRegUnit
  import diskRegPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   accEn,
  input  logic                   accWr,
  input  logic [DRV_W-1:0]       accDrv,
  input  logic [OFS_W-1:0]       accOfs,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  output logic                   nxReg,
  output logic                   attnOut,
  input  logic [DRV_N-1:0]       driveEn,
  input  logic [DRV_N-1:0]       mediumOn,
  input  logic [DRV_N-1:0]       lockEn,
  input  logic [DRV_N*TRK_W-1:0] lockTrack,
  input  logic [DRV_N-1:0]       bigType,
  input  logic [DATA_W-1:0]      lookAhead,
  output logic                   startOp,
  output logic [DRV_W-1:0]       startDrive,
  output logic [FN_W-1:0]        startFunc,
  output logic [DATA_W-1:0]      startAddr,
  input  logic                   doneValid,
  input  logic [DRV_W-1:0]       doneDrive
);
  ctrlStrobeT stb;
  logic       selBusy, selErrAny;
  logic [2:0] selAddrHi;

  diskRegCtrl ctrl_i (
    .accEn(accEn), .accWr(accWr), .accDrv(accDrv), .accOfs(accOfs), .wrData(wrData),
    .selBusy(selBusy), .selErrAny(selErrAny), .selMedium(mediumOn[accDrv]),
    .selAddrHi(selAddrHi), .stb(stb), .nxReg(nxReg)
  );

  diskRegPath path_i (
    .clk(clk), .rstN(rstN), .stb(stb), .accDrv(accDrv), .accOfs(accOfs), .wrData(wrData),
    .driveEn(driveEn), .mediumOn(mediumOn), .lockEn(lockEn), .lockTrack(lockTrack),
    .bigType(bigType), .lookAhead(lookAhead), .doneValid(doneValid), .doneDrive(doneDrive),
    .rdData(rdData), .attnOut(attnOut), .startOp(startOp), .startDrive(startDrive),
    .startFunc(startFunc), .startAddr(startAddr), .selBusy(selBusy),
    .selErrAny(selErrAny), .selAddrHi(selAddrHi)
  );
endmodule

// File: rtl/diskRegChk.sv
module diskRegChk
  import diskRegPkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   accEn,
  input logic                   accWr,
  input logic [DRV_W-1:0]       accDrv,
  input logic [OFS_W-1:0]       accOfs,
  input logic [DATA_W-1:0]      wrData,
  input logic [DATA_W-1:0]      rdData,
  input logic                   nxReg,
  input logic                   attnOut,
  input logic [DRV_N-1:0]       driveEn,
  input logic [DRV_N-1:0]       mediumOn,
  input logic                   startOp,
  input logic [DRV_W-1:0]       startDrive,
  input logic [FN_W-1:0]        startFunc,
  input logic [DATA_W-1:0]      startAddr
);
  AST_NX_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && accOfs >= OFS_W'(8)) |-> (nxReg && rdData == '0)); // R1
  AST_CTL_AVAIL: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !accWr && accOfs == OFS_W'(0)) |-> rdData[11]); // R1
  AST_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !accWr && accOfs == OFS_W'(1) && driveEn[accDrv]) |-> rdData[8]); // R10
  AST_ATTN_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !accWr && accOfs == OFS_W'(4)) |-> (attnOut == (rdData[DRV_N-1:0] != '0))); // R11
  AST_START_AFTER_GO: assert property (@(posedge clk) disable iff (!rstN)
    startOp |-> $past(accEn && accWr && accOfs == OFS_W'(0) && wrData[0])); // R8
  AST_START_FUNC: assert property (@(posedge clk) disable iff (!rstN)
    startOp |-> (startFunc == FN_SEEK || startFunc == FN_WCHK ||
                 startFunc == FN_WRITE || startFunc == FN_READ)); // R8
  AST_START_MEDIUM: assert property (@(posedge clk) disable iff (!rstN)
    startOp |-> mediumOn[startDrive]); // R7
  AST_START_ADDR_OK: assert property (@(posedge clk) disable iff (!rstN)
    startOp |-> (startAddr[14:12] == 3'b000)); // R7
endmodule

bind diskRegUnit diskRegChk chk_i (
  .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr), .accDrv(accDrv),
  .accOfs(accOfs), .wrData(wrData), .rdData(rdData), .nxReg(nxReg),
  .attnOut(attnOut), .driveEn(driveEn), .mediumOn(mediumOn), .startOp(startOp),
  .startDrive(startDrive), .startFunc(startFunc), .startAddr(startAddr)
);

// File: tb/diskRegUnit_tb.sv
module diskRegUnit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accEn = 1'b0, accWr = 1'b0;
  logic [2:0]  accDrv = '0;
  logic [4:0]  accOfs = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        nxReg, attnOut;
  logic [7:0]  driveEn  = 8'h7F;
  logic [7:0]  mediumOn = 8'hF7;
  logic [7:0]  lockEn   = 8'h04;
  logic [47:0] lockTrack = 48'd5 << 12;
  logic [7:0]  bigType  = 8'h02;
  logic [15:0] lookAhead = 16'h1234;
  logic        startOp;
  logic [2:0]  startDrive;
  logic [4:0]  startFunc;
  logic [15:0] startAddr;
  logic        doneValid = 1'b0;
  logic [2:0]  doneDrive = '0;

  int nRun = 0, nFail = 0, startCnt = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) if (startOp) startCnt++;

  diskRegUnit dut_i (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr), .accDrv(accDrv),
    .accOfs(accOfs), .wrData(wrData), .rdData(rdData), .nxReg(nxReg),
    .attnOut(attnOut), .driveEn(driveEn), .mediumOn(mediumOn), .lockEn(lockEn),
    .lockTrack(lockTrack), .bigType(bigType), .lookAhead(lookAhead),
    .startOp(startOp), .startDrive(startDrive), .startFunc(startFunc),
    .startAddr(startAddr), .doneValid(doneValid), .doneDrive(doneDrive)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] d, input logic [4:0] o, input logic [15:0] v);
    @(negedge clk);
    accEn = 1'b1; accWr = 1'b1; accDrv = d; accOfs = o; wrData = v;
    @(negedge clk);
    accEn = 1'b0; accWr = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] d, input logic [4:0] o, output logic [15:0] v);
    accEn = 1'b1; accWr = 1'b0; accDrv = d; accOfs = o;
    #1 v = rdData;
    accEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [2:0] d, input logic [4:0] o,
                       input logic [15:0] exp);
    logic [15:0] v;
    @(negedge clk);
    rd(d, o, v);
    check(tag, v, exp);
  endtask

  task automatic done(input logic [2:0] d);
    @(negedge clk);
    doneValid = 1'b1; doneDrive = d;
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic tReset;
    rdChk("R12 status drive0", 0, 1, 16'h1180);
    rdChk("R12 error drive0", 0, 2, 16'h0000);
    rdChk("R12 ctl drive0", 0, 0, 16'h0800);
    rdChk("R12 addr drive0", 0, 5, 16'h0000);
    rdChk("R12 maint drive0", 0, 3, 16'h0000);
    rdChk("R12 disabled status", 7, 1, 16'h0000);
    rdChk("R12 disabled error", 7, 2, 16'h0000);
    rdChk("R10 no medium status", 3, 1, 16'h0180);
    check("R11 attnOut idle", {15'b0, attnOut}, 16'h0000);
  endtask

  task automatic tMap;
    logic [15:0] v;
    rdChk("R1 type big", 1, 6, 16'h0002);
    rdChk("R1 type small", 0, 6, 16'h0000);
    rdChk("R1 lookahead", 0, 7, 16'h1234);
    wr(0, 3, 16'hBEEF);
    rdChk("R1 maint rw", 0, 3, 16'hBEEF);
    @(negedge clk);
    accEn = 1'b1; accWr = 1'b0; accDrv = 0; accOfs = 5'd9;
    #1 check("R1 nx flag", {15'b0, nxReg}, 16'h0001);
    check("R1 nx data", rdData, 16'h0000);
    accEn = 1'b0;
  endtask

  task automatic tStore;
    wr(0, 0, 16'hFFFE);
    rdChk("R2 ctl field only", 0, 0, 16'h083E);
    wr(0, 2, 16'hFFFF);
    rdChk("R2 error ignores write", 0, 2, 16'h0000);
    wr(0, 1, 16'hFFFF);
    rdChk("R2 status ignores write", 0, 1, 16'h1180);
    wr(1, 6, 16'h0000);
    rdChk("R2 type ignores write", 1, 6, 16'h0002);
  endtask

  task automatic tLock;
    wr(2, 5, 16'h0140);
    rdChk("R10 lock at track", 2, 1, 16'h1980);
    wr(2, 5, 16'h0180);
    rdChk("R10 lock above track", 2, 1, 16'h1180);
  endtask

  task automatic tCommands;
    wr(0, 0, 16'h0007);
    rdChk("R3 illegal err", 0, 2, 16'h0001);
    rdChk("R3 illegal status", 0, 1, 16'hD180);
    check("R3 attnOut", {15'b0, attnOut}, 16'h0001);
    wr(0, 0, 16'h0001);
    rdChk("R4 nop with error", 0, 2, 16'h0001);
    rdChk("R4 attn re-raised", 0, 4, 16'h0001);
    wr(0, 0, 16'h0005);
    rdChk("R5 clear status", 0, 1, 16'h1180);
    rdChk("R5 clear err", 0, 2, 16'h0000);
    check("R4 attn cleared by start", {15'b0, attnOut}, 16'h0000);
    wr(0, 0, 16'h0001);
    rdChk("R5 nop status", 0, 1, 16'h1180);
  endtask

  task automatic tAttn;
    wr(4, 0, 16'h0007);
    wr(5, 0, 16'h0007);
    rdChk("R11 summary", 0, 4, 16'h0030);
    wr(0, 4, 16'h0010);
    rdChk("R11 partial clear", 0, 4, 16'h0020);
    check("R11 attnOut on", {15'b0, attnOut}, 16'h0001);
    wr(0, 4, 16'h0020);
    rdChk("R11 all clear", 0, 4, 16'h0000);
    check("R11 attnOut off", {15'b0, attnOut}, 16'h0000);
  endtask

  task automatic tUnsafe;
    wr(3, 0, 16'h000D);
    rdChk("R7 unsafe err", 3, 2, 16'h4000);
    rdChk("R7 unsafe status", 3, 1, 16'hC180);
    wr(6, 5, 16'h1000);
    wr(6, 0, 16'h001D);
    rdChk("R7 bad address err", 6, 2, 16'h0400);
    check("R7 no start", 16'(startCnt), 16'h0000);
  endtask

  task automatic tLaunch;
    wr(0, 5, 16'h0041);
    wr(0, 0, 16'h000D);
    #1;
    check("R8 startOp", {15'b0, startOp}, 16'h0001);
    check("R8 startDrive", {13'b0, startDrive}, 16'h0000);
    check("R8 startFunc", {11'b0, startFunc}, 16'h0006);
    check("R8 startAddr", startAddr, 16'h0041);
    rdChk("R8 busy status", 0, 1, 16'h3100);
    check("R8 single pulse", 16'(startCnt), 16'h0001);
    wr(0, 5, 16'h0007);
    rdChk("R6 addr kept", 0, 5, 16'h0041);
    rdChk("R6 refuse err", 0, 2, 16'h0004);
    rdChk("R6 refuse status", 0, 1, 16'hF100);
    wr(0, 4, 16'h0001);
    rdChk("R6 summary write while busy", 0, 1, 16'h7100);
    done(0);
    rdChk("R9 search done", 0, 1, 16'hD180);
    wr(0, 0, 16'h0005);
    rdChk("R9 cleared", 0, 1, 16'h1180);
    wr(1, 0, 16'h001D);
    #1 check("R8 read func", {11'b0, startFunc}, 16'h000E);
    rdChk("R8 read busy", 1, 1, 16'h1100);
    done(1);
    rdChk("R9 read done no attn", 1, 1, 16'h1180);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tMap();
    tStore();
    tLock();
    tCommands();
    tAttn();
    tUnsafe();
    tLaunch();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule